// File: doc/BRIEF.md
# Dual Calendar Alarm with Interrupt / Clock Pin

This block watches the live clock/calendar fields presented by a separate calendar counter and compares them against two independent alarm slots. Each slot holds one compare value per calendar field, a field-enable mask and a small control set: armed, repeat and interrupt enable. A field whose enable bit is clear always counts as matching. Matching every field is therefore possible, as are "every minute", "every Tuesday" or one exact time and date.

The comparison is taken only on the once-per-second strobe. An alarm fires when its match turns from false to true. Firing sets a sticky status flag that the host polls and clears by writing a one to it. A one-shot alarm disarms itself when it fires. A repeating alarm stays armed and fires again on every later rising edge of its match.

A single output pin serves two purposes. In interrupt mode it is an active-low request, low while any flag with interrupt enable is set. In one of three clock modes it is a square wave built from the half-period strobes of a 1 Hz, 100 Hz or 32.768 kHz time base. A byte-wide register port sets up the slots, the control bits, the status flags and the pin mode.

Top module: `calarm_top`

## Requirements
- R1: After reset, all alarm flags read 0, the pin is high, the pin mode is interrupt (0), and every control, mask and compare register reads 0.
- R2: Calendar field f sits at bits [8f+7:8f] of `cal_now` (f = 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday). An armed alarm matches when every field whose mask bit f is 1 equals the slot's compare byte f. Fields with mask bit 0 are ignored.
- R3: Matches are evaluated only in cycles where `sec_tick` is high. A match with no tick changes no flag.
- R4: A flag is set only on a tick where the match is true and the match was false at the previous tick. A match held over several ticks sets the flag once.
- R5: Writing to status address 0x11 clears flag a wherever data bit a is 1 and leaves it alone where bit a is 0. If a fire and a clear of the same flag fall in one cycle, the flag ends up set.
- R6: With repeat off, the alarm's armed bit reads 0 after the alarm fires.
- R7: With repeat on, the alarm stays armed and fires again at the next rising edge of its match.
- R8: In interrupt mode the pin is low one cycle after any flag whose interrupt enable is 1 is set. The pin is high one cycle after no such flag remains.
- R9: The pin mode at address 0x12, bits [1:0], is: 1 = 1 Hz, 2 = 100 Hz, 3 = 32.768 kHz. In these modes the pin inverts one cycle after each strobe of the selected rate and ignores the other strobes and the flags.
- R10: The two alarms are independent. Alarm a drives only flag bit a.
- R11: Register map. Alarm a's compare byte f is at address 8a+f and its mask is at 8a+7 (bits [6:0]). Control at 0x10 holds the alarm a bits at 4a+0 (armed), 4a+1 (repeat) and 4a+2 (interrupt enable). Writes can be read back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_now | input | 56 | Live calendar fields, 8 bits each |
| sec_tick | input | 1 | One-cycle strobe per second; alarm evaluation point |
| tog_1hz | input | 1 | Half-period strobe of the 1 Hz time base |
| tog_100hz | input | 1 | Half-period strobe of the 100 Hz time base |
| tog_32k | input | 1 | Half-period strobe of the 32.768 kHz time base |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| alarm_flags | output | 2 | Sticky alarm flags |
| pin_o | output | 1 | Active-low interrupt or clock output |

## Verification
A register write is visible on `reg_rdata` after the one rising edge that stores it. A flag changes at the first rising edge after the `sec_tick` cycle. The pin follows one edge later in interrupt mode, and one edge after a selected strobe in clock modes. The bench drives every stimulus for exactly one cycle from a falling edge. It samples at the falling edge after those counted edges, so a pin check after a tick waits one extra half-cycle pair beyond the flag check. Checks that something does not happen sample after the edge where the change would have occurred.

// File: rtl/calarm_pkg.sv
package calarm_pkg;
  localparam int unsigned NFIELD     = 7;
  localparam int unsigned FW         = 8;
  localparam int unsigned NALM       = 2;
  localparam int unsigned AW         = 5;
  localparam int unsigned SLOT_SPAN  = 8;
  localparam int unsigned CTRL_PITCH = 4;
  localparam logic [AW-1:0] ADR_CTRL = 5'h10;
  localparam logic [AW-1:0] ADR_STAT = 5'h11;
  localparam logic [AW-1:0] ADR_PIN  = 5'h12;

  typedef enum logic [1:0] {
    PIN_IRQ   = 2'd0,
    PIN_1HZ   = 2'd1,
    PIN_100HZ = 2'd2,
    PIN_32K   = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic irq_en;
    logic rpt;
    logic armed;
  } alm_ctrl_t;
endpackage

// File: rtl/calarm_rst_sync.sv
module calarm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/calarm_slot.sv
module calarm_slot
  import calarm_pkg::*;
#(
  parameter int unsigned NF  = NFIELD,
  parameter int unsigned FWD = FW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF*FWD-1:0] cal_now,
  input  logic              sec_tick,
  input  logic [NF-1:0]     wr_val,
  input  logic              wr_mask,
  input  logic              wr_ctrl,
  input  logic [FWD-1:0]    wdata,
  input  alm_ctrl_t         ctrl_wdata,
  input  logic              clr_flag,
  output logic [NF*FWD-1:0] val_o,
  output logic [NF-1:0]     mask_o,
  output alm_ctrl_t         ctrl_o,
  output logic              flag_o
);
  logic [NF*FWD-1:0] val_q, val_d;
  logic [NF-1:0]     mask_q, mask_d;
  alm_ctrl_t         ctrl_q, ctrl_d;
  logic              prev_q, prev_d;
  logic              flag_q, flag_d;
  logic [NF-1:0]     field_hit;
  logic              match;
  logic              fire;

  // per-field compare; a masked-off field always hits
  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign field_hit[g] = ~mask_q[g] | (cal_now[g*FWD +: FWD] == val_q[g*FWD +: FWD]);
  end

  assign match = ctrl_q.armed & (&field_hit);
  assign fire  = sec_tick & match & ~prev_q;

  always_comb begin
    val_d = val_q;
    for (int f = 0; f < NF; f++) begin
      if (wr_val[f]) val_d[f*FWD +: FWD] = wdata;
    end
    mask_d = wr_mask ? wdata[NF-1:0] : mask_q;

    ctrl_d = ctrl_q;
    if (wr_ctrl)                    ctrl_d       = ctrl_wdata;
    else if (fire && !ctrl_q.rpt)   ctrl_d.armed = 1'b0;

    prev_d = sec_tick ? match : prev_q;

    if (fire)          flag_d = 1'b1;
    else if (clr_flag) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      mask_q <= mask_d;
      ctrl_q <= ctrl_d;
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign val_o  = val_q;
  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;

  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(sec_tick)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_flag) |=> flag_q); // R5
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl_q.rpt && !wr_ctrl) |=> !ctrl_q.armed); // R6
  AST_REPEAT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl_q.rpt && !wr_ctrl) |=> ctrl_q.armed); // R7
endmodule

// File: rtl/calarm_pin.sv
module calarm_pin
  import calarm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      tog_1hz,
  input  logic      tog_100hz,
  input  logic      tog_32k,
  input  logic      irq_req,
  output logic      pin_o
);
  logic pin_q, pin_d;
  logic sel_strobe;

  always_comb begin
    case (mode)
      PIN_1HZ:   sel_strobe = tog_1hz;
      PIN_100HZ: sel_strobe = tog_100hz;
      PIN_32K:   sel_strobe = tog_32k;
      default:   sel_strobe = 1'b0;
    endcase
    if (mode == PIN_IRQ) pin_d = ~irq_req;
    else if (sel_strobe) pin_d = ~pin_q;
    else                 pin_d = pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  AST_CLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PIN_IRQ && !sel_strobe) |=> $stable(pin_q)); // R9
endmodule

// File: rtl/calarm_top.sv
module calarm_top
  import calarm_pkg::*;
#(
  parameter int unsigned NF  = NFIELD,
  parameter int unsigned FWD = FW
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [NF*FWD-1:0] cal_now,
  input  logic              sec_tick,
  input  logic              tog_1hz,
  input  logic              tog_100hz,
  input  logic              tog_32k,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [FWD-1:0]    reg_wdata,
  output logic [FWD-1:0]    reg_rdata,
  output logic [NALM-1:0]   alarm_flags,
  output logic              pin_o
);
  logic rst_n;

  logic [NALM-1:0][NF-1:0]     wr_val;
  logic [NALM-1:0]             wr_mask;
  logic [NALM-1:0]             clr_flag;
  logic                        wr_ctrl;
  logic [NALM-1:0][NF*FWD-1:0] val_a;
  logic [NALM-1:0][NF-1:0]     mask_a;
  alm_ctrl_t [NALM-1:0]        ctrl_a;
  logic [NALM-1:0]             flag_a;
  logic [NALM-1:0]             irq_src;
  logic                        irq_req;
  pin_mode_e                   mode_q, mode_d;

  calarm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);

  for (genvar a = 0; a < NALM; a++) begin : g_alm
    for (genvar f = 0; f < NF; f++) begin : g_wr
      assign wr_val[a][f] = reg_wr && (reg_addr == AW'(a*SLOT_SPAN + f));
    end
    assign wr_mask[a]  = reg_wr && (reg_addr == AW'(a*SLOT_SPAN + SLOT_SPAN - 1));
    assign clr_flag[a] = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[a];
    assign irq_src[a]  = flag_a[a] & ctrl_a[a].irq_en;

    calarm_slot #(.NF(NF), .FWD(FWD)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_now    (cal_now),
      .sec_tick   (sec_tick),
      .wr_val     (wr_val[a]),
      .wr_mask    (wr_mask[a]),
      .wr_ctrl    (wr_ctrl),
      .wdata      (reg_wdata),
      .ctrl_wdata (alm_ctrl_t'(reg_wdata[a*CTRL_PITCH +: 3])),
      .clr_flag   (clr_flag[a]),
      .val_o      (val_a[a]),
      .mask_o     (mask_a[a]),
      .ctrl_o     (ctrl_a[a]),
      .flag_o     (flag_a[a])
    );
  end

  assign irq_req = |irq_src;

  always_comb begin
    mode_d = mode_q;
    if (reg_wr && reg_addr == ADR_PIN) mode_d = pin_mode_e'(reg_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PIN_IRQ;
    else        mode_q <= mode_d;
  end

  calarm_pin u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .tog_1hz   (tog_1hz),
    .tog_100hz (tog_100hz),
    .tog_32k   (tog_32k),
    .irq_req   (irq_req),
    .pin_o     (pin_o)
  );

  always_comb begin
    reg_rdata = '0;
    for (int a = 0; a < NALM; a++) begin
      for (int f = 0; f < NF; f++) begin
        if (reg_addr == AW'(a*SLOT_SPAN + f)) reg_rdata = val_a[a][f*FWD +: FWD];
      end
      if (reg_addr == AW'(a*SLOT_SPAN + SLOT_SPAN - 1)) reg_rdata[NF-1:0] = mask_a[a];
    end
    if (reg_addr == ADR_CTRL) begin
      for (int a = 0; a < NALM; a++) reg_rdata[a*CTRL_PITCH +: 3] = ctrl_a[a];
    end
    if (reg_addr == ADR_STAT) reg_rdata[NALM-1:0] = flag_a;
    if (reg_addr == ADR_PIN)  reg_rdata[1:0]      = mode_q;
  end

  assign alarm_flags = flag_a;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PIN_IRQ && irq_src == '0) |=> pin_o); // R8
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PIN_IRQ && mode_d == PIN_IRQ && irq_src != '0) |=> !pin_o); // R8
endmodule

// File: tb/sim_calarm_top.sv
`timescale 1ns/1ps
module sim_calarm_top;
  logic        clk = 1'b0;
  logic        arst_n;
  logic [55:0] cal_now;
  logic        sec_tick, tog_1hz, tog_100hz, tog_32k;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [1:0]  alarm_flags;
  logic        pin_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  calarm_top u0 (
    .clk(clk), .arst_n(arst_n), .cal_now(cal_now), .sec_tick(sec_tick),
    .tog_1hz(tog_1hz), .tog_100hz(tog_100hz), .tog_32k(tog_32k),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_flags(alarm_flags), .pin_o(pin_o)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // fields: w y mo d h m s
  task automatic set_time(input logic [7:0] w, mo, d, h, m, s);
    cal_now = {w, 8'h26, mo, d, h, m, s};
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(alarm_flags, 0, "R1", "flags after reset");
    check(pin_o, 1, "R1", "pin after reset");
    rd(5'h10, d); check(d, 0, "R1", "ctrl after reset");
    rd(5'h12, d); check(d, 0, "R1", "pin mode after reset");
    rd(5'h0A, d); check(d, 0, "R1", "alarm1 hour after reset");
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(5'h0A, 8'h23); rd(5'h0A, d); check(d, 8'h23, "R11", "alarm1 hour readback");
    wr(5'h07, 8'h45); rd(5'h07, d); check(d, 8'h45, "R11", "alarm0 mask readback");
    wr(5'h10, 8'h62); rd(5'h10, d); check(d, 8'h62, "R11", "ctrl readback");
    wr(5'h10, 8'h00);
  endtask

  task automatic t_match_mask();
    logic [7:0] d;
    wr(5'h00, 8'h30); wr(5'h01, 8'h15); wr(5'h02, 8'h09);
    wr(5'h07, 8'h03); wr(5'h10, 8'h01);
    set_time(8'h1, 8'h3, 8'h21, 8'h05, 8'h16, 8'h30);
    tick(); check(alarm_flags, 0, "R2", "minute mismatch no flag");
    set_time(8'h1, 8'h3, 8'h21, 8'h05, 8'h15, 8'h30);
    repeat (3) @(negedge clk);
    check(alarm_flags, 0, "R3", "match without tick");
    tick(); check(alarm_flags, 1, "R2", "match with masked hour differing");
    rd(5'h10, d); check(d[0], 0, "R6", "one-shot disarmed");
    @(negedge clk); check(pin_o, 1, "R8", "pin high without irq enable");
    wr(5'h11, 8'h00); check(alarm_flags, 1, "R5", "write 0 keeps flag");
    wr(5'h11, 8'h01); check(alarm_flags, 0, "R5", "write 1 clears flag");
  endtask

  task automatic t_irq();
    set_time(8'h1, 8'h3, 8'h21, 8'h05, 8'h00, 8'h00);
    wr(5'h10, 8'h05);
    tick();
    set_time(8'h1, 8'h3, 8'h21, 8'h05, 8'h15, 8'h30);
    tick();
    check(alarm_flags, 1, "R8", "flag set before pin");
    check(pin_o, 1, "R8", "pin not yet low");
    @(negedge clk); check(pin_o, 0, "R8", "pin low one cycle after flag");
    wr(5'h11, 8'h01);
    check(pin_o, 0, "R8", "pin still low in clear cycle");
    @(negedge clk); check(pin_o, 1, "R8", "pin high after clear");
  endtask

  task automatic t_repeat();
    logic [7:0] d;
    wr(5'h07, 8'h00); wr(5'h10, 8'h00);
    wr(5'h0E, 8'h02); wr(5'h0F, 8'h40); wr(5'h10, 8'h30);
    set_time(8'h2, 8'h3, 8'h21, 8'h05, 8'h15, 8'h30);
    tick(); check(alarm_flags, 2, "R10", "only alarm1 flag");
    wr(5'h11, 8'h02);
    tick(); check(alarm_flags, 0, "R4", "held match no refire");
    rd(5'h10, d); check(d[4], 1, "R7", "repeat keeps armed");
    set_time(8'h3, 8'h3, 8'h21, 8'h05, 8'h15, 8'h30); tick();
    set_time(8'h2, 8'h3, 8'h21, 8'h05, 8'h15, 8'h30);
    tick(); check(alarm_flags, 2, "R7", "repeat refires");
    set_time(8'h3, 8'h3, 8'h21, 8'h05, 8'h15, 8'h30); tick();
    // fire and clear in one cycle
    @(negedge clk);
    set_time(8'h2, 8'h3, 8'h21, 8'h05, 8'h15, 8'h30);
    sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = 5'h11; reg_wdata = 8'h02;
    @(negedge clk); sec_tick = 1'b0; reg_wr = 1'b0;
    check(alarm_flags, 2, "R5", "set wins over clear");
    wr(5'h11, 8'h03);
  endtask

  task automatic t_both();
    wr(5'h10, 8'h00);
    wr(5'h01, 8'h10); wr(5'h07, 8'h02);
    wr(5'h09, 8'h20); wr(5'h0F, 8'h02);
    set_time(8'h4, 8'h3, 8'h21, 8'h05, 8'h00, 8'h00); tick();
    wr(5'h10, 8'h11);
    set_time(8'h4, 8'h3, 8'h21, 8'h05, 8'h10, 8'h00);
    tick(); check(alarm_flags, 1, "R10", "alarm0 alone fires");
    set_time(8'h4, 8'h3, 8'h21, 8'h05, 8'h20, 8'h00);
    tick(); check(alarm_flags, 3, "R10", "alarm1 fires, alarm0 kept");
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      1: tog_1hz = 1'b1;
      2: tog_100hz = 1'b1;
      default: tog_32k = 1'b1;
    endcase
    @(negedge clk); tog_1hz = 1'b0; tog_100hz = 1'b0; tog_32k = 1'b0;
  endtask

  task automatic t_freq();
    logic p;
    wr(5'h12, 8'h01);
    @(negedge clk); p = pin_o;
    pulse(2); check(pin_o, p, "R9", "1Hz mode ignores 100Hz strobe");
    pulse(1); check(pin_o, !p, "R9", "1Hz strobe toggles pin");
    pulse(1); check(pin_o, p, "R9", "1Hz strobe toggles back");
    wr(5'h12, 8'h03);
    p = pin_o;
    pulse(1); check(pin_o, p, "R9", "32k mode ignores 1Hz strobe");
    pulse(3); check(pin_o, !p, "R9", "32k strobe toggles pin");
  endtask

  initial begin
    arst_n = 1'b0; sec_tick = 1'b0; tog_1hz = 1'b0; tog_100hz = 1'b0; tog_32k = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; cal_now = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_match_mask();
    t_irq();
    t_repeat();
    t_both();
    t_freq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule